// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one general-purpose timer channel clocked from the bus clock. A 16-bit prescaler divides the bus clock into ticks, and each tick advances a 16-bit free-running counter. The channel pin can work in one of five modes: GPIO input, GPIO output, input capture, output compare and PWM. In capture mode the counter value is latched on a chosen pin edge, so software can measure the time between events. In compare mode a match between the counter and a programmed value changes the pin in one of five ways. In PWM mode the pin carries a waveform whose period and high time are set in counter ticks.

The same channel also holds a reloadable watchdog. This is a down-counter on the bus clock that raises a reset request when it runs out while enabled. A service write restarts it from the last loaded count. Software drives the channel through four 32-bit registers. Any capture or compare event sets a status flag, and the interrupt output shows that flag when interrupts are enabled.

Register map, selected by `bus_addr_i`:

- Address 0, configuration.
  - Bits [2:0] set the mode: 0 GPIO input, 1 GPIO output, 2 capture, 3 compare, 4 PWM. Codes 5 to 7 behave as GPIO input.
  - Bits [5:3] set the compare action.
  - Bits [7:6] set the capture edge.
  - Bit 8 is the GPIO output level.
  - Bit 9 is the interrupt enable.
  - Bit 10 is the watchdog enable.
  - Bits [31:16] hold the prescale value.
- Address 1, limits. Bits [15:0] hold the compare value, which is also the PWM period. Bits [31:16] hold the PWM high time.
- Address 2, status. Bits [15:0] hold the captured value. Bit 16 is the event flag. Bit 17 is the synchronised pin level.
- Address 3, watchdog and counter. Bits [15:0] read the free-running counter and bits [31:16] read the remaining watchdog count.

Top module: `timer_chan`

## Requirements
- R1: After reset, `pin_oe_o`, `irq_o` and `wd_rst_o` are low, and the configuration, limit and status registers read as zero.
- R2: With prescale value P, the counter advances by exactly one every P+1 bus cycles and never changes by any other step. The prescale field (configuration bits [31:16]) reads back as zero.
- R3: In capture mode, the counter is latched on the pin edges chosen by configuration bits [7:6]: 1 rising, 2 falling, 3 both, 0 none. With prescale 0, the difference between two captured values equals the spacing of the two edges in bus cycles.
- R4: Every capture or compare match sets the status flag (status bit 16). Writing 1 to that bit clears the flag, and a new event in the same cycle wins over the clear. `irq_o` equals the flag while the interrupt enable (configuration bit 9) is set, and is low otherwise.
- R5: In compare mode (mode 3), the pin action happens in the same cycle that the counter takes the compare value (limit bits [15:0]).
- R6: Compare action 2 drives the pin high for one counter tick and then low. Action 3 drives it low for one tick and then high.
- R7: Compare action 0 drives the pin high, action 1 drives it low, and action 4 inverts it.
- R8: In PWM mode (mode 4) with period N and high time W, the pin is high for min(W,N) ticks in every N-tick period. W of 0 holds the pin low, and W of N or more holds it high.
- R9: In GPIO output mode (mode 1), the pin is driven to configuration bit 8 with `pin_oe_o` high. In GPIO input mode (mode 0), `pin_oe_o` is low and status bit 17 follows the pin after synchronisation.
- R10: A write to address 3 with bit 31 clear loads a watchdog count from bits [15:0]. A write with bit 31 set reloads the last loaded count. While the watchdog is enabled (configuration bit 10), the count falls by one each bus cycle, and `wd_rst_o` stays high while it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register |
| pin_i | input | 1 | Channel pin input level |
| pin_o | output | 1 | Channel pin output level |
| pin_oe_o | output | 1 | Channel pin output enable |
| irq_o | output | 1 | Interrupt request |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
The bench checks compare timing by polling the counter until it equals the compare value, then expects the pin to have changed in that very cycle. A design that matched one tick late, or acted on the old counter value, would show the old level at that point. Pulse actions are followed for one more cycle to catch a pulse that sticks or lasts two ticks. PWM is driven from a table that includes a zero high time and a high time above the period, where an off-by-one comparison would produce one extra or one missing high tick per period. The watchdog is counted cycle by cycle to its expiry and then serviced, so a design that reloaded from the wrong value, or released the reset without a service write, is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        MODE_GPIN  = 3'd0,
        MODE_GPOUT = 3'd1,
        MODE_CAPT  = 3'd2,
        MODE_CMP   = 3'd3,
        MODE_PWM   = 3'd4
    } tmr_mode_e;

    typedef enum logic [2:0] {
        ACT_SET    = 3'd0,
        ACT_CLR    = 3'd1,
        ACT_PPULSE = 3'd2,
        ACT_NPULSE = 3'd3,
        ACT_TOGGLE = 3'd4
    } cmp_act_e;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_LIM  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_WDOG = 2'd3;
endpackage

// File: rtl/tmr_base.sv
module tmr_base #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PS_W-1:0]  prescale_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [PS_W-1:0]  pre;
        logic [CNT_W-1:0] cnt;
    } base_t;

    base_t q, d;
    logic  tick;

    always_comb begin
        d    = q;
        tick = (q.pre >= prescale_i);
        if (tick) begin
            d.pre = '0;
            d.cnt = q.cnt + CNT_W'(1);
        end else begin
            d.pre = q.pre + PS_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tick_o  = tick;
    assign count_o = q.cnt;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             enable_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             event_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             level_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic [CNT_W-1:0]  cap;
    } cap_t;

    cap_t q, d;
    logic lvl, rise, fall, hit;

    always_comb begin
        d      = q;
        lvl    = q.sync[SYNC_N-1];
        rise   = lvl & ~q.prev;
        fall   = ~lvl & q.prev;
        hit    = enable_i & ((edge_sel_i[0] & rise) | (edge_sel_i[1] & fall));
        d.sync = {q.sync[SYNC_N-2:0], pin_i};
        d.prev = lvl;
        if (hit) d.cap = count_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign event_o = hit;
    assign cap_o   = q.cap;
    assign level_o = lvl;
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [2:0]       mode_i,
    input  logic [2:0]       act_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             gpio_i,
    output logic             pin_o,
    output logic             match_o
);
    typedef struct packed {
        logic             out;
        logic             pend;
        logic             pend_lvl;
        logic [CNT_W-1:0] phase;
    } wave_t;

    wave_t            q, d;
    logic             match;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W:0]   phase_inc;

    always_comb begin
        d         = q;
        match     = 1'b0;
        cnt_nxt   = count_i + CNT_W'(1);
        phase_inc = {1'b0, q.phase} + (CNT_W+1)'(1);
        case (mode_i)
            MODE_GPOUT: begin
                d.out  = gpio_i;
                d.pend = 1'b0;
            end
            MODE_CMP: begin
                if (tick_i) begin
                    if (cnt_nxt == compare_i) begin
                        match = 1'b1;
                        d.pend = 1'b0;
                        case (act_i)
                            ACT_SET:    d.out = 1'b1;
                            ACT_CLR:    d.out = 1'b0;
                            ACT_PPULSE: begin d.out = 1'b1; d.pend = 1'b1; d.pend_lvl = 1'b0; end
                            ACT_NPULSE: begin d.out = 1'b0; d.pend = 1'b1; d.pend_lvl = 1'b1; end
                            ACT_TOGGLE: d.out = ~q.out;
                            default:    d.out = q.out;
                        endcase
                    end else if (q.pend) begin
                        d.out  = q.pend_lvl;
                        d.pend = 1'b0;
                    end
                end
            end
            MODE_PWM: begin
                d.pend = 1'b0;
                if (tick_i) begin
                    if (phase_inc >= {1'b0, compare_i}) d.phase = '0;
                    else                                d.phase = phase_inc[CNT_W-1:0];
                end
                d.out = (d.phase < width_i);
            end
            default: begin
                d.pend  = 1'b0;
                d.phase = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pin_o   = q.out;
    assign match_o = match;
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic            load_i,
    input  logic            service_i,
    input  logic [WD_W-1:0] value_i,
    output logic [WD_W-1:0] remain_o,
    output logic            rst_o
);
    typedef struct packed {
        logic [WD_W-1:0] rem;
        logic [WD_W-1:0] reload;
    } wd_t;

    wd_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.reload = value_i;
            d.rem    = value_i;
        end else if (service_i) begin
            d.rem = q.reload;
        end else if (en_i && (q.rem != '0)) begin
            d.rem = q.rem - WD_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign remain_o = q.rem;
    assign rst_o    = en_i & (q.rem == '0);
endmodule

// File: rtl/timer_chan.sv
module timer_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_we_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        pin_i,
    output logic        pin_o,
    output logic        pin_oe_o,
    output logic        irq_o,
    output logic        wd_rst_o
);
    localparam int BUS_W  = 32;
    localparam int HI_LSB = BUS_W / 2;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            wd_en;
        logic            irq_en;
        logic            gpio;
        logic [1:0]      edge_sel;
        logic [2:0]      act;
        logic [2:0]      mode;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [BUS_W-1:0] lim;
        logic             flag;
    } regs_t;

    regs_t q, d;

    logic             wr_cfg, wr_lim, wr_stat, wr_wdog;
    logic             tick, cap_evt, cmp_hit, pin_lvl;
    logic [CNT_W-1:0] count, cap_val, wd_rem;
    logic [2:0]       mode_w;
    logic             wd_en_w, flag_q;
    logic [BUS_W-1:0] lim_q;
    logic [4:0]       unused_wdata;

    assign wr_cfg  = bus_we_i & (bus_addr_i == ADDR_CFG);
    assign wr_lim  = bus_we_i & (bus_addr_i == ADDR_LIM);
    assign wr_stat = bus_we_i & (bus_addr_i == ADDR_STAT);
    assign wr_wdog = bus_we_i & (bus_addr_i == ADDR_WDOG);

    always_comb begin
        d = q;
        if (wr_cfg) begin
            d.cfg.mode     = bus_wdata_i[2:0];
            d.cfg.act      = bus_wdata_i[5:3];
            d.cfg.edge_sel = bus_wdata_i[7:6];
            d.cfg.gpio     = bus_wdata_i[8];
            d.cfg.irq_en   = bus_wdata_i[9];
            d.cfg.wd_en    = bus_wdata_i[10];
            d.cfg.ps       = bus_wdata_i[HI_LSB +: PS_W];
        end
        if (wr_lim) d.lim = bus_wdata_i;
        if (cap_evt || cmp_hit)           d.flag = 1'b1;
        else if (wr_stat && bus_wdata_i[16]) d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mode_w       = q.cfg.mode;
    assign wd_en_w      = q.cfg.wd_en;
    assign flag_q       = q.flag;
    assign lim_q        = q.lim;
    assign unused_wdata = bus_wdata_i[15:11];

    tmr_base #(.CNT_W(CNT_W), .PS_W(PS_W)) u_base (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .prescale_i (q.cfg.ps),
        .tick_o     (tick),
        .count_o    (count)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_N(2)) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .enable_i   (mode_w == MODE_CAPT),
        .edge_sel_i (q.cfg.edge_sel),
        .count_i    (count),
        .event_o    (cap_evt),
        .cap_o      (cap_val),
        .level_o    (pin_lvl)
    );

    tmr_wave #(.CNT_W(CNT_W)) u_wave (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .count_i   (count),
        .mode_i    (mode_w),
        .act_i     (q.cfg.act),
        .compare_i (lim_q[CNT_W-1:0]),
        .width_i   (lim_q[HI_LSB +: CNT_W]),
        .gpio_i    (q.cfg.gpio),
        .pin_o     (pin_o),
        .match_o   (cmp_hit)
    );

    tmr_wdog #(.WD_W(CNT_W)) u_wd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (wd_en_w),
        .load_i    (wr_wdog & ~bus_wdata_i[31]),
        .service_i (wr_wdog & bus_wdata_i[31]),
        .value_i   (bus_wdata_i[CNT_W-1:0]),
        .remain_o  (wd_rem),
        .rst_o     (wd_rst_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_CFG: begin
                bus_rdata_o[2:0] = q.cfg.mode;
                bus_rdata_o[5:3] = q.cfg.act;
                bus_rdata_o[7:6] = q.cfg.edge_sel;
                bus_rdata_o[8]   = q.cfg.gpio;
                bus_rdata_o[9]   = q.cfg.irq_en;
                bus_rdata_o[10]  = q.cfg.wd_en;
            end
            ADDR_LIM: bus_rdata_o = lim_q;
            ADDR_STAT: begin
                bus_rdata_o[CNT_W-1:0] = cap_val;
                bus_rdata_o[16]        = q.flag;
                bus_rdata_o[17]        = pin_lvl;
            end
            default: begin
                bus_rdata_o[CNT_W-1:0]     = count;
                bus_rdata_o[HI_LSB +: CNT_W] = wd_rem;
            end
        endcase
    end

    assign pin_oe_o = (mode_w == MODE_GPOUT) | (mode_w == MODE_CMP) | (mode_w == MODE_PWM);
    assign irq_o    = q.flag & q.cfg.irq_en;
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bus_we_i,
    input logic [1:0]       bus_addr_i,
    input logic [31:0]      bus_wdata_i,
    input logic             pin_o,
    input logic             wd_rst_o,
    input logic [CNT_W-1:0] count,
    input logic             flag_q,
    input logic             cap_evt,
    input logic             cmp_hit,
    input logic [2:0]       mode_w,
    input logic             wd_en_w,
    input logic [31:0]      lim_q
);
    logic pwm_zero;
    assign pwm_zero = (mode_w == MODE_PWM) && (lim_q[16 +: CNT_W] == '0);

    AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (count != $past(count)) |-> (count == $past(count) + CNT_W'(1))) else $error("counter stepped wrongly"); // R2
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) (cap_evt || cmp_hit) |=> flag_q) else $error("event lost"); // R4
    AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni) (bus_we_i && bus_addr_i == ADDR_STAT && bus_wdata_i[16] && !cap_evt && !cmp_hit) |=> !flag_q) else $error("flag not cleared"); // R4
    AST_MATCH_AT_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_hit |=> (count == $past(lim_q[CNT_W-1:0]))) else $error("match off value"); // R5
    AST_PWM_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) pwm_zero |=> (!pin_o || !pwm_zero)) else $error("pwm zero not low"); // R8
    AST_WD_RESET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (wd_rst_o && wd_en_w && !bus_we_i) |=> wd_rst_o) else $error("watchdog released"); // R10
endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pin_o       (pin_o),
    .wd_rst_o    (wd_rst_o),
    .count       (count),
    .flag_q      (flag_q),
    .cap_evt     (cap_evt),
    .cmp_hit     (cmp_hit),
    .mode_w      (mode_w),
    .wd_en_w     (wd_en_w),
    .lim_q       (lim_q)
);

// File: tb/sim_timer_chan.sv
module sim_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq, wd_rst;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    timer_chan u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin_in),
        .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq), .wd_rst_o(wd_rst)
    );

    // prescale, period, width, expected high cycles in one period
    localparam logic [15:0] PWM_TAB [5][4] = '{
        '{16'd0, 16'd10, 16'd3, 16'd3},
        '{16'd1, 16'd8,  16'd0, 16'd0},
        '{16'd0, 16'd6,  16'd6, 16'd6},
        '{16'd2, 16'd5,  16'd9, 16'd15},
        '{16'd1, 16'd7,  16'd4, 16'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic cmp_case(input logic [2:0] act, input logic e_at, input logic e_after, input string tag);
        logic [31:0] v;
        logic [15:0] target;
        wr(2'd0, {16'd0, 10'd0, act, 3'd3});
        rd(2'd3, v);
        target = v[15:0] + 16'd16;
        wr(2'd1, {16'd0, target});
        wr(2'd2, 32'h0001_0000);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            rd(2'd3, v);
            if (v[15:0] == target) break;
        end
        check({tag, " counter reached compare value"}, {16'd0, v[15:0]}, {16'd0, target});
        check({tag, " pin at match cycle"}, {31'd0, pin_out}, {31'd0, e_at});
        @(negedge clk);
        check({tag, " pin one tick later"}, {31'd0, pin_out}, {31'd0, e_after});
    endtask

    initial begin
        logic [31:0] v, c1, c2;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", {31'd0, pin_oe}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 wd_rst", {31'd0, wd_rst}, 32'd0);
        rd(2'd0, v); check("R1 cfg", v, 32'd0);
        rd(2'd1, v); check("R1 lim", v, 32'd0);
        rd(2'd2, v); check("R1 stat", v, 32'd0);

        // PWM table walk (R8)
        for (int k = 0; k < 5; k++) begin
            int ps, per, wid, cyc;
            ps = int'(PWM_TAB[k][0]); per = int'(PWM_TAB[k][1]);
            wid = int'(PWM_TAB[k][2]); cyc = per * (ps + 1);
            wr(2'd1, {PWM_TAB[k][2], PWM_TAB[k][1]});
            wr(2'd0, {PWM_TAB[k][0], 13'd0, 3'd4});
            repeat (3 * cyc + 10) @(negedge clk);
            highs = 0;
            for (int i = 0; i < cyc; i++) begin
                @(negedge clk);
                if (pin_out) highs++;
            end
            check($sformatf("R8 pwm row %0d width %0d high cycles", k, wid), highs, {16'd0, PWM_TAB[k][3]});
            check("R8 pwm drives pin", {31'd0, pin_oe}, 32'd1);
        end

        // R2 prescaler
        wr(2'd0, {16'd3, 16'd0});
        rd(2'd0, v); check("R2 prescale not readable", v, 32'd0);
        rd(2'd3, c1);
        repeat (8) @(negedge clk);
        rd(2'd3, c2);
        check("R2 divide by four", {16'd0, c2[15:0] - c1[15:0]}, 32'd2);

        // R9 GPIO
        wr(2'd0, {16'd0, 7'd0, 1'b1, 8'd1});
        @(negedge clk);
        check("R9 gpio out high", {30'd0, pin_oe, pin_out}, 32'd3);
        wr(2'd0, {16'd0, 7'd0, 1'b0, 8'd1});
        @(negedge clk);
        check("R9 gpio out low", {30'd0, pin_oe, pin_out}, 32'd2);
        wr(2'd0, 32'd0);
        check("R9 gpio in no drive", {31'd0, pin_oe}, 32'd0);
        pin_in = 1'b1; repeat (3) @(negedge clk);
        rd(2'd2, v); check("R9 input level high", {31'd0, v[17]}, 32'd1);
        pin_in = 1'b0; repeat (3) @(negedge clk);
        rd(2'd2, v); check("R9 input level low", {31'd0, v[17]}, 32'd0);

        // R3 capture rising, irq enabled (R4)
        wr(2'd0, {16'd0, 6'd0, 1'b1, 1'b0, 2'd1, 3'd0, 3'd2});
        wr(2'd2, 32'h0001_0000);
        @(negedge clk); pin_in = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd2, c1);
        check("R4 flag after capture", {31'd0, c1[16]}, 32'd1);
        check("R4 irq with enable", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0001_0000);
        rd(2'd2, v); check("R4 flag cleared by write one", {31'd0, v[16]}, 32'd0);
        check("R4 irq dropped", {31'd0, irq}, 32'd0);
        pin_in = 1'b0;
        repeat (27) @(negedge clk);
        pin_in = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd2, c2);
        check("R3 rising spacing", {16'd0, c2[15:0] - c1[15:0]}, 32'd37);

        // R3 capture falling
        wr(2'd0, {16'd0, 8'd0, 2'd2, 3'd0, 3'd2});
        @(negedge clk); pin_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd2, c1);
        repeat (4) @(negedge clk); pin_in = 1'b1;
        repeat (13) @(negedge clk); pin_in = 1'b0;
        repeat (8) @(negedge clk);
        rd(2'd2, c2);
        check("R3 falling spacing", {16'd0, c2[15:0] - c1[15:0]}, 32'd23);

        // R3 capture both edges
        wr(2'd0, {16'd0, 8'd0, 2'd3, 3'd0, 3'd2});
        @(negedge clk); pin_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd2, c1);
        repeat (3) @(negedge clk); pin_in = 1'b0;
        repeat (7) @(negedge clk);
        rd(2'd2, c2);
        check("R3 both-edge spacing", {16'd0, c2[15:0] - c1[15:0]}, 32'd9);

        // R3 edge select none
        wr(2'd0, {16'd0, 8'd0, 2'd0, 3'd0, 3'd2});
        wr(2'd2, 32'h0001_0000);
        repeat (2) begin
            @(negedge clk); pin_in = 1'b1;
            repeat (5) @(negedge clk); pin_in = 1'b0;
            repeat (5) @(negedge clk);
        end
        rd(2'd2, v);
        check("R3 no edge no flag", {31'd0, v[16]}, 32'd0);
        check("R3 no edge value kept", {16'd0, v[15:0]}, {16'd0, c2[15:0]});

        // R5 R7 R6 compare actions
        cmp_case(3'd0, 1'b1, 1'b1, "R5 R7 set");
        cmp_case(3'd1, 1'b0, 1'b0, "R7 clear");
        cmp_case(3'd4, 1'b1, 1'b1, "R7 toggle");
        cmp_case(3'd3, 1'b0, 1'b1, "R6 negative pulse");
        cmp_case(3'd2, 1'b1, 1'b0, "R6 positive pulse");
        rd(2'd2, v);
        check("R4 flag after compare", {31'd0, v[16]}, 32'd1);
        check("R4 irq masked", {31'd0, irq}, 32'd0);

        // R10 watchdog
        wr(2'd3, 32'd5);
        wr(2'd0, 32'h0000_0400);
        check("R10 armed no reset", {31'd0, wd_rst}, 32'd0);
        repeat (4) @(negedge clk);
        check("R10 one left", {31'd0, wd_rst}, 32'd0);
        @(negedge clk);
        check("R10 expiry reset", {31'd0, wd_rst}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 reset held", {31'd0, wd_rst}, 32'd1);
        wr(2'd3, 32'h8000_0000);
        check("R10 service releases", {31'd0, wd_rst}, 32'd0);
        rd(2'd3, v);
        check("R10 reload original count", {16'd0, v[31:16]}, 32'd5);
        repeat (5) @(negedge clk);
        check("R10 second expiry", {31'd0, wd_rst}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule